// File: doc/BRIEF.md
# Frame Frequency Predictor

This block picks an operating point for a video encoder before each frame is encoded. While the new frame streams past, an accumulator adds up the absolute difference between each incoming pixel and the co-located pixel of the frame before it. When the encoder asks for a prediction, a fixed-point linear model combines five values. Three are counts from the previous frame: macroblock matches, valid blocks and valid coefficients. The fourth is the signed change in quantizer step. The fifth is the accumulated frame difference. The model also adds a constant term. The weighted sum is converted to MHz. In one step, that conversion applies the frame rate and a deliberate ten percent over-prediction margin, so the clock is rarely set too low.

The predicted MHz value is then matched against an ascending table of operating frequencies. The block returns the index of the slowest entry that still meets the prediction. The step index and the MHz value are registered together and pulse `done`. They then stay unchanged until the next prediction, so the selected point holds for the whole frame. The model weights, the table entries and the number of active table steps are all held in registers written through a simple write port.

Top module: `ffwd_freq_predictor`

## Requirements
- R1: On each cycle with `pix_valid`, the difference sum grows by |cur_pix − ref_pix|. `frame_start` clears the sum. If `pix_valid` is high in the same cycle as `frame_start`, that pixel becomes the first term of the new sum.
- R2: The difference sum saturates at its all-ones value. In the default configuration it is 23 bits wide, so the limit is 8388607.
- R3: Weights are signed values with 16 fractional bits. They sit at write addresses 0 (constant), 1 (match count), 2 (valid blocks), 3 (valid coefficients), 4 (difference sum) and 5 (quantizer change). A `predict` strobe samples the three counts and the signed `dq`, then forms S = w0 + w1·match + w2·vblk + w3·vcoef + w4·diffsum + w5·dq.
- R4: When S is 0 or more, `pred_mhz` = floor(S·70867 / 2^48). This value is 70867 ≈ 15 × 1.1 × 2^32 / 10^6, so the conversion includes the frame rate and the margin.
- R5: When S is negative, `pred_mhz` is 0 and the step index is 0.
- R6: When the converted value exceeds 65535, `pred_mhz` saturates to 65535.
- R7: `step_idx` is the lowest index i, below the active step count, whose table entry is at least `pred_mhz`. If no entry qualifies, it is the active step count minus 1.
- R8: After reset, the weights round to 9601460, 1140.098, 2297.982, 331.4708, 3.400078 and 125670.7. The table holds 189, 297 and 405 MHz at indices 0, 1 and 2, and the active step count is 3. `step_idx`, `pred_mhz` and `done` are 0.
- R9: Address 6 sets the active step count. A written 0 becomes 1, and a value above 9 becomes 9. Addresses 16 to 24 write table entries 0 to 8 from the low 16 data bits. Writes to any other address change nothing.
- R10: `done` goes high for one cycle, three clock edges after the edge that samples `predict`. `step_idx` and `pred_mhz` change only at that moment and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Clears the difference sum |
| pix_valid | input | 1 | Pixel pair valid this cycle |
| cur_pix | input | 8 | Pixel of the frame being analysed |
| ref_pix | input | 8 | Co-located pixel of the previous frame |
| predict | input | 1 | Start a prediction |
| prev_match | input | 16 | Previous-frame macroblock match count |
| prev_vblk | input | 16 | Previous-frame valid block count |
| prev_vcoef | input | 16 | Previous-frame valid coefficient count |
| dq | input | 6 | Signed quantizer step change |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 44 | Register write data |
| step_idx | output | 4 | Selected operating point |
| pred_mhz | output | 16 | Margined predicted frequency |
| done | output | 1 | Result valid pulse |

## Verification
The bench sweeps the predicted value one MHz at a time across every boundary of the default three-step table and of a nine-step table. A lookup that used strict comparison, or that picked the highest qualifying entry, would land one step off exactly at the table frequencies. Pixel frames cover every difference value in both directions. They include a pixel arriving on the clearing strobe and a frame long enough to overflow the sum. An unsigned absolute-difference stage, a clear that drops that pixel, or a wrapping sum would each produce a visibly wrong frequency. Negative model sums, clipped frequencies, clamped step-count writes and writes to unmapped addresses are also driven. These catch a lookup that treats a negative sum as huge, a result that wraps instead of clipping, and a decoder that aliases unused addresses onto live registers.

// File: rtl/ffwd_freq_predictor.sv
`timescale 1ns/1ps
module ffwd_freq_predictor #(
  parameter int PIX_W       = 8,
  parameter int FRAME_W     = 176,
  parameter int FRAME_H     = 144,
  parameter int STAT_W      = 16,
  parameter int DQ_W        = 6,
  parameter int CW          = 44,
  parameter int FRAC        = 16,
  parameter int MHZ_W       = 16,
  parameter int MAX_STEPS   = 9,
  parameter int SCALE       = 70867,
  parameter int SCALE_SHIFT = 32,
  parameter int ADDR_W      = 5,
  parameter int DEF_STEPS   = 3,
  parameter int DEF_F0      = 189,
  parameter int DEF_F1      = 297,
  parameter int DEF_F2      = 405
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          pix_valid,
  input  logic [PIX_W-1:0]              cur_pix,
  input  logic [PIX_W-1:0]              ref_pix,
  input  logic                          predict,
  input  logic [STAT_W-1:0]             prev_match,
  input  logic [STAT_W-1:0]             prev_vblk,
  input  logic [STAT_W-1:0]             prev_vcoef,
  input  logic signed [DQ_W-1:0]        dq,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [CW-1:0]                 cfg_wdata,
  output logic [$clog2(MAX_STEPS)-1:0]  step_idx,
  output logic [MHZ_W-1:0]              pred_mhz,
  output logic                          done
);
  localparam int NPIX     = FRAME_W * FRAME_H;
  localparam int ABS_W    = $clog2(NPIX * ((1 << PIX_W) - 1) + 1);
  localparam int SI_W     = $clog2(MAX_STEPS);
  localparam int CNT_W    = $clog2(MAX_STEPS + 1);
  localparam int OPND_W   = (ABS_W > STAT_W) ? ABS_W : STAT_W;
  localparam int ACC_W    = CW + OPND_W + 4;
  localparam int PROD_W   = ACC_W + $clog2(SCALE + 1) + 1;
  localparam int TBL_BASE = 16;
  localparam int NCOEF    = 6;
  localparam logic signed [PROD_W-1:0] SCALE_P = PROD_W'(SCALE);
  localparam logic signed [PROD_W-1:0] MHZ_MAX = PROD_W'((1 << MHZ_W) - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_STEPS);

  localparam logic signed [CW-1:0] W_DEF0 = CW'(longint'(9601460.0  * (2.0 ** FRAC)));
  localparam logic signed [CW-1:0] W_DEF1 = CW'(longint'(1140.098   * (2.0 ** FRAC)));
  localparam logic signed [CW-1:0] W_DEF2 = CW'(longint'(2297.982   * (2.0 ** FRAC)));
  localparam logic signed [CW-1:0] W_DEF3 = CW'(longint'(331.4708   * (2.0 ** FRAC)));
  localparam logic signed [CW-1:0] W_DEF4 = CW'(longint'(3.400078   * (2.0 ** FRAC)));
  localparam logic signed [CW-1:0] W_DEF5 = CW'(longint'(125670.7   * (2.0 ** FRAC)));

  // programmable state
  logic signed [CW-1:0] wgt [NCOEF];
  logic [MHZ_W-1:0]     tbl [MAX_STEPS];
  logic [CNT_W-1:0]     nsteps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wgt[0] <= W_DEF0; wgt[1] <= W_DEF1; wgt[2] <= W_DEF2;
      wgt[3] <= W_DEF3; wgt[4] <= W_DEF4; wgt[5] <= W_DEF5;
      nsteps <= CNT_W'(DEF_STEPS);
      for (int i = 0; i < MAX_STEPS; i++) tbl[i] <= '0;
      tbl[0] <= MHZ_W'(DEF_F0);
      tbl[1] <= MHZ_W'(DEF_F1);
      tbl[2] <= MHZ_W'(DEF_F2);
    end else if (cfg_we) begin
      if (int'(cfg_addr) < NCOEF)
        wgt[int'(cfg_addr)] <= cfg_wdata;
      else if (int'(cfg_addr) == NCOEF) begin
        if (cfg_wdata == '0)                  nsteps <= CNT_W'(1);
        else if (cfg_wdata > CW'(MAX_STEPS))  nsteps <= CNT_MAX;
        else                                  nsteps <= CNT_W'(cfg_wdata);
      end else if (int'(cfg_addr) >= TBL_BASE && int'(cfg_addr) < TBL_BASE + MAX_STEPS)
        tbl[int'(cfg_addr) - TBL_BASE] <= cfg_wdata[MHZ_W-1:0];
    end
  end

  // frame difference accumulator
  logic [ABS_W-1:0] acc;
  logic [PIX_W-1:0] pdiff;
  logic [ABS_W:0]   acc_sum;
  assign pdiff   = (cur_pix > ref_pix) ? cur_pix - ref_pix : ref_pix - cur_pix;
  assign acc_sum = {1'b0, acc} + (ABS_W+1)'(pdiff);

  always_ff @(posedge clk) begin
    if (!rst_n)           acc <= '0;
    else if (frame_start) acc <= pix_valid ? ABS_W'(pdiff) : '0;
    else if (pix_valid)   acc <= acc_sum[ABS_W] ? '1 : acc_sum[ABS_W-1:0];
  end

  // stage 1: weighted sum
  logic signed [ACC_W-1:0] t_match, t_vblk, t_vcoef, t_abs, t_dq, sum_d, sum_q;
  assign t_match = ACC_W'(wgt[1]) * ACC_W'($signed({1'b0, prev_match}));
  assign t_vblk  = ACC_W'(wgt[2]) * ACC_W'($signed({1'b0, prev_vblk}));
  assign t_vcoef = ACC_W'(wgt[3]) * ACC_W'($signed({1'b0, prev_vcoef}));
  assign t_abs   = ACC_W'(wgt[4]) * ACC_W'($signed({1'b0, acc}));
  assign t_dq    = ACC_W'(wgt[5]) * ACC_W'(dq);
  assign sum_d   = ACC_W'(wgt[0]) + t_match + t_vblk + t_vcoef + t_abs + t_dq;

  // stage 2: frequency conversion with margin
  logic signed [PROD_W-1:0] prod, shifted;
  logic [MHZ_W-1:0] mhz_d, mhz_q;
  assign prod    = PROD_W'(sum_q) * SCALE_P;
  assign shifted = prod >>> (FRAC + SCALE_SHIFT);
  assign mhz_d   = (sum_q < 0)         ? '0 :
                   (shifted > MHZ_MAX) ? '1 : MHZ_W'(shifted);

  // stage 3: table lookup
  logic [MAX_STEPS-1:0] hit;
  logic [SI_W-1:0]      sel;
  for (genvar g = 0; g < MAX_STEPS; g++) begin : g_hit
    assign hit[g] = (CNT_W'(g) < nsteps) && (tbl[g] >= mhz_q);
  end

  always_comb begin
    sel = SI_W'(nsteps - CNT_W'(1));
    for (int i = MAX_STEPS - 1; i >= 0; i--)
      if (hit[i]) sel = SI_W'(i);
  end

  logic v1, v2, done_q;
  logic [SI_W-1:0]  step_q;
  logic [MHZ_W-1:0] pred_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; done_q <= 1'b0;
      sum_q <= '0; mhz_q <= '0; step_q <= '0; pred_q <= '0;
    end else begin
      v1     <= predict;
      v2     <= v1;
      done_q <= v2;
      if (predict) sum_q <= sum_d;
      if (v1)      mhz_q <= mhz_d;
      if (v2) begin
        step_q <= sel;
        pred_q <= mhz_q;
      end
    end
  end

  assign step_idx = step_q;
  assign pred_mhz = pred_q;
  assign done     = done_q;

  assert_acc_monotone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> acc >= $past(acc));
  assert_steps_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nsteps >= CNT_W'(1) && nsteps <= CNT_MAX);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    predict |-> ##3 done_q);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(step_q) && $stable(pred_q)));
  assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !$past(cfg_we)) |-> (CNT_W'(step_q) < nsteps));
  assert_step_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !$past(cfg_we) && step_q != '0) |-> (tbl[step_q - SI_W'(1)] < pred_q));
  assert_step_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !$past(cfg_we) && tbl[step_q] < pred_q) |-> (CNT_W'(step_q) == nsteps - CNT_W'(1)));
endmodule

// File: tb/ffwd_freq_predictor_tb_top.sv
`timescale 1ns/1ps
module ffwd_freq_predictor_tb_top;
  localparam int CLK_P = 10;
  localparam longint ABS_MAX = (64'd1 << 23) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, pix_valid = 0, predict = 0, cfg_we = 0;
  logic [7:0] cur_pix = 0, ref_pix = 0;
  logic [15:0] prev_match = 0, prev_vblk = 0, prev_vcoef = 0;
  logic signed [5:0] dq = 0;
  logic [4:0] cfg_addr = 0;
  logic [43:0] cfg_wdata = 0;
  logic [3:0] step_idx;
  logic [15:0] pred_mhz;
  logic done;

  ffwd_freq_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .cur_pix(cur_pix), .ref_pix(ref_pix), .predict(predict),
    .prev_match(prev_match), .prev_vblk(prev_vblk), .prev_vcoef(prev_vcoef), .dq(dq),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .step_idx(step_idx), .pred_mhz(pred_mhz), .done(done));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic signed [43:0] sw [6];
  logic [15:0] stbl [9];
  int sn;
  longint exp_abs = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input logic [43:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
    if (addr < 6) sw[addr] = data;
    else if (addr == 6) sn = (data == 0) ? 1 : (data > 9) ? 9 : int'(data);
    else if (addr >= 16 && addr < 25) stbl[addr-16] = data[15:0];
  endtask

  task automatic pixels(input int n, input int mode, input bit start);
    for (int i = 0; i < n; i++) begin
      int c, r;
      longint d;
      @(negedge clk);
      case (mode)
        0: begin c = i % 256; r = 255 - (i % 256); end
        1: begin c = i % 256; r = 128; end
        2: begin c = 255; r = 0; end
        default: begin c = (i*37 + 11) % 256; r = (i*91 + 5) % 256; end
      endcase
      cur_pix = 8'(c); ref_pix = 8'(r); pix_valid = 1;
      frame_start = start && (i == 0);
      d = (c > r) ? c - r : r - c;
      if (start && i == 0) exp_abs = d;
      else begin exp_abs += d; if (exp_abs > ABS_MAX) exp_abs = ABS_MAX; end
    end
    @(negedge clk);
    pix_valid = 0; frame_start = 0;
  endtask

  task automatic clear_frame;
    @(negedge clk); frame_start = 1; pix_valid = 0;
    @(negedge clk); frame_start = 0;
    exp_abs = 0;
  endtask

  function automatic logic signed [127:0] exp_sum(input longint n, vb, vc, input int q);
    logic signed [127:0] s;
    s = 128'(sw[0]);
    s += 128'(sw[1]) * 128'(n);
    s += 128'(sw[2]) * 128'(vb);
    s += 128'(sw[3]) * 128'(vc);
    s += 128'(sw[4]) * 128'(exp_abs);
    s += 128'(sw[5]) * 128'(q);
    return s;
  endfunction

  function automatic longint exp_mhz(input logic signed [127:0] s);
    logic signed [127:0] m;
    if (s < 0) return 0;
    m = (s * 128'sd70867) >>> 48;
    return (m > 65535) ? 65535 : longint'(m);
  endfunction

  function automatic int exp_step(input longint m);
    for (int i = 0; i < sn; i++) if (longint'(stbl[i]) >= m) return i;
    return sn - 1;
  endfunction

  task automatic run_predict(input longint n, vb, vc, input int q, input string req);
    longint em;
    int es, lat;
    logic [3:0] s0;
    logic [15:0] m0;
    em = exp_mhz(exp_sum(n, vb, vc, q));
    es = (em == 0 && exp_sum(n, vb, vc, q) < 0) ? 0 : exp_step(em);
    @(negedge clk);
    predict = 1; prev_match = 16'(n); prev_vblk = 16'(vb); prev_vcoef = 16'(vc); dq = 6'(q);
    @(negedge clk);
    predict = 0; lat = 1;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    chk(lat == 3, {req, " R10 latency"}, lat, 3);
    chk(pred_mhz == 16'(em), {req, " pred_mhz"}, pred_mhz, em);
    chk(step_idx == 4'(es), {req, " step_idx R7"}, step_idx, es);
    s0 = step_idx; m0 = pred_mhz;
    @(negedge clk);
    @(negedge clk);
    chk(!done && step_idx == s0 && pred_mhz == m0, "R10 hold", {step_idx, pred_mhz}, {s0, m0});
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [43:0] unit;
    sw[0] = 44'(longint'(9601460.0 * 65536.0));
    sw[1] = 44'(longint'(1140.098 * 65536.0));
    sw[2] = 44'(longint'(2297.982 * 65536.0));
    sw[3] = 44'(longint'(331.4708 * 65536.0));
    sw[4] = 44'(longint'(3.400078 * 65536.0));
    sw[5] = 44'(longint'(125670.7 * 65536.0));
    for (int i = 0; i < 9; i++) stbl[i] = 0;
    stbl[0] = 189; stbl[1] = 297; stbl[2] = 405; sn = 3;

    repeat (4) @(negedge clk);
    chk(step_idx == 0 && pred_mhz == 0 && done == 0, "R8 reset outputs", {step_idx, pred_mhz}, 0);
    rst_n = 1;
    @(negedge clk);

    // R8 / R3: defaults with several statistics sets, incl. negative dq
    run_predict(0, 0, 0, 0, "R8 defaults");
    chk(pred_mhz == 158, "R8 default base", pred_mhz, 158);
    run_predict(6000, 300, 2000, 0, "R3 stats A");
    run_predict(9000, 500, 6000, 3, "R3 stats B");
    run_predict(2000, 100, 900, -4, "R3 negative dq");
    pixels(500, 3, 1);
    run_predict(4000, 200, 1500, -32, "R3 with diffs");

    // R1: accumulator exposed through w4
    for (int k = 0; k < 6; k++) if (k != 4) cfg_write(k, 0);
    cfg_write(4, 44'(60607 * 65536));
    pixels(256, 0, 1);  run_predict(0, 0, 0, 0, "R1 mirrored sweep");
    pixels(256, 1, 1);  run_predict(0, 0, 0, 0, "R1 fixed ref sweep");
    pixels(256, 3, 1);  run_predict(0, 0, 0, 0, "R1 mixed sweep");
    pixels(5, 2, 1);    run_predict(0, 0, 0, 0, "R1 start with pixel");
    chk(exp_abs == 1275, "R1 first pixel counted", exp_abs, 1275);
    pixels(10, 1, 0);   run_predict(0, 0, 0, 0, "R1 continue");
    clear_frame;        run_predict(0, 0, 0, 0, "R1 clear");
    chk(pred_mhz == 0, "R1 cleared sum", pred_mhz, 0);

    // R2: saturation of the sum
    cfg_write(4, 44'(65536));
    pixels(33000, 2, 1);
    run_predict(0, 0, 0, 0, "R2 saturated sum");
    chk(pred_mhz == 138, "R2 saturation value", pred_mhz, 138);
    clear_frame;
    cfg_write(4, 0);

    // R5: negative sums
    cfg_write(0, 44'(-64'sd1000 * 65536));
    run_predict(0, 0, 0, 0, "R5 negative constant");
    cfg_write(0, 0);
    cfg_write(5, 44'(100 * 65536));
    run_predict(0, 0, 0, -5, "R5 negative dq term");
    cfg_write(5, 0);

    // R6: clip
    cfg_write(1, 44'(64'd1 << 38));
    run_predict(65535, 0, 0, 0, "R6 clip");
    chk(pred_mhz == 16'hFFFF && step_idx == 2, "R6 clipped top step", pred_mhz, 65535);

    // R4 / R7: sweep over default table boundaries
    unit = 44'(((128'd1 << 48) + 128'd70866) / 128'd70867);
    cfg_write(1, unit);
    for (int t = 0; t <= 450; t++) run_predict(t, 0, 0, 0, "R4 R7 default sweep");

    // R9 / R7: nine-step table
    for (int i = 0; i < 9; i++) cfg_write(16 + i, 44'(189 + 27*i));
    cfg_write(6, 9);
    for (int t = 100; t <= 420; t++) run_predict(t, 0, 0, 0, "R9 R7 nine-step sweep");

    // R9: step-count clamps and unmapped writes
    cfg_write(6, 0);
    run_predict(300, 0, 0, 0, "R9 clamp low");
    chk(step_idx == 0, "R9 count 0 becomes 1", step_idx, 0);
    cfg_write(6, 15);
    run_predict(500, 0, 0, 0, "R9 clamp high");
    chk(step_idx == 8, "R9 count 15 becomes 9", step_idx, 8);
    cfg_write(7, '1);
    cfg_write(30, '1);
    cfg_write(12, '1);
    run_predict(250, 0, 0, 0, "R9 unmapped writes ignored");
    chk(pred_mhz == 250 && step_idx == 3, "R9 unmapped no effect", {step_idx, pred_mhz}, {4'd3, 16'd250});

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule